// File: doc/BRIEF.md
# Quad Down-Counting Timer with Watchdog Registers

This block is a register-mapped timer unit. It holds four independent down-counters and one watchdog counter pair, reached through a single-cycle 32-bit register bus. Software preloads a channel's live count or its reload value, then starts it through a shared control word. In that word every channel has three bits: run, reload-on-expiry and tick source. A running channel steps down by one on every core clock cycle. If its tick-source bit is set, it steps only on cycles where the `ref_tick` strobe is high. That strobe is a one-cycle pulse, synchronous to `clk`, from a slower reference.

When a channel with reload-on-expiry set is sitting at zero and gets a tick, it loads its reload value and keeps running. A reload value of 0xFFFFFFFF gives a free-running wrap. Without that bit, the channel parks at zero. Each time a count steps from one to zero, the channel raises a one-cycle expiry pulse. The watchdog value register counts down on every core cycle until it reaches zero. Its reload register is plain storage. Turning the watchdog into a reset source is left to the surrounding logic.

The bus has no stall and no handshake. A write with `bus_en` and `bus_we` high takes effect at the next rising clock edge. Read data is combinational from the addressed register, so it reflects the state before that edge. The register map fits at most four channels. Addresses are byte addresses, and the two low address bits are ignored.

Top module: `qrt_top`

## Requirements
- R1: While `rst_n` is low, the control word, all counts, all reload values and both watchdog registers reset to zero, and `expire` is low.
- R2: The registers are mapped at these word-aligned byte offsets:
  - 0x00: control word.
  - 0x10+8n: reload value of channel n.
  - 0x14+8n: live count of channel n.
  - 0x30: watchdog reload.
  - 0x34: watchdog value.

  A write (`bus_en`=1, `bus_we`=1) updates the addressed register at the clock edge. `bus_rdata` shows the addressed register's current content combinationally.
- R3: In the control word, bit 2n is channel n's run bit, bit 2n+1 is its reload-on-expiry bit, and bit 11+n is its tick-source bit. All other bits ignore writes and read as zero, so writing all ones reads back 0x000078FF.
- R4: A running channel with tick-source 0 decreases by one at every clock edge. With tick-source 1, it decreases only at edges where `ref_tick` is high. A change to the control word first affects stepping at the edge after the write.
- R5: A channel whose run bit is clear keeps its count. Setting the run bit resumes counting from that count.
- R6: A running channel with reload-on-expiry set that is at zero on a tick loads its reload value at that edge. For example, a reload of 0xFFFFFFFF gives 0 followed by 0xFFFFFFFF.
- R7: A running channel with reload-on-expiry clear stays at zero. A write to its reload register while its count is zero also copies the written value into the count.
- R8: A write to a count register overrides any step in the same cycle, and the written value is read back on the following cycle.
- R9: Bit n of `expire` is high for exactly one cycle, the cycle after a tick steps channel n's count from 1 to 0. Writing zero to a count never raises it.
- R10: The watchdog value decreases by one at every clock edge while it is nonzero and is not being written, and it stays at zero. Both watchdog registers read back what was written.
- R11: Offsets 0x04 to 0x0C and offsets above 0x34 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| expire | output | 4 | Per-channel one-cycle expiry pulse |

## Verification
The assertions check these properties on every cycle:
- A stopped channel does not move.
- A channel on the reference tick holds between strobes.
- A parked channel without reload stays at zero.
- A count write wins over a step.
- The expiry pulse is one cycle long and coincides with a zero count.
- The watchdog value steps or parks.
- At most one register is selected by any write.

The bench's scenarios are the only way to show the address map, the control-word bit positions and the masking of unused bits. They also cover the zero-to-reload wrap value, the reload write that restarts a parked channel, and the one-edge delay before a control change takes effect. A fixed-seed random mix of reads, writes and reference strobes is compared cycle by cycle with a register-level model.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  // Word indices (byte offset / 4) of the register map.
  localparam int unsigned WORD_CTRL    = 0;
  localparam int unsigned WORD_CH_BASE = 4;   // reload at base+2n, count at base+2n+1
  localparam int unsigned WORD_WD_RL   = 12;
  localparam int unsigned WORD_WD_VAL  = 13;
  localparam int unsigned SRC_BIT_BASE = 11;
  localparam int unsigned MAX_CH       = 4;

  function automatic logic [31:0] ctrl_mask(input int unsigned nch);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < nch; i++) begin
      m[2*i]            = 1'b1;
      m[2*i+1]          = 1'b1;
      m[SRC_BIT_BASE+i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/qrt_decode.sv
module qrt_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctrl_wr,
  output logic [NUM_CH-1:0] rl_wr,
  output logic [NUM_CH-1:0] val_wr,
  output logic              wdr_wr,
  output logic              wdv_wr,
  output logic [31:0]       word_idx
);
  import qrt_pkg::*;

  logic wr;
  logic unused_lsb;

  assign unused_lsb = ^bus_addr[1:0];
  assign wr         = bus_en && bus_we;
  assign word_idx   = 32'(bus_addr[ADDR_W-1:2]);

  assign ctrl_wr = wr && (word_idx == WORD_CTRL);
  assign wdr_wr  = wr && (word_idx == WORD_WD_RL);
  assign wdv_wr  = wr && (word_idx == WORD_WD_VAL);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign rl_wr[n]  = wr && (word_idx == WORD_CH_BASE + 2*n);
    assign val_wr[n] = wr && (word_idx == WORD_CH_BASE + 2*n + 1);
  end
endmodule

// File: rtl/qrt_channel.sv
module qrt_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             auto_rl,
  input  logic             use_ref,
  input  logic             ref_tick,
  input  logic             val_wr,
  input  logic             rl_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic step;
  logic at_zero;

  assign step    = run && (!use_ref || ref_tick);
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      expire <= 1'b0;
    end else begin
      if (rl_wr) reload <= wdata;
      if (val_wr)                count <= wdata;
      else if (rl_wr && at_zero) count <= wdata;
      else if (step)             count <= at_zero ? (auto_rl ? reload : '0) : count - 1'b1;
      expire <= !val_wr && step && (count == ONE);
    end
  end

  // R5: stopped channel holds
  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !val_wr && !rl_wr) |=> $stable(count));
  // R4: reference-selected channel holds between strobes
  assert_ref_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ref && !ref_tick && !val_wr && !rl_wr) |=> $stable(count));
  // R7: parked without reload stays at zero
  assert_park_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_rl && at_zero && !val_wr && !rl_wr) |=> (count == '0));
  // R8: count write wins
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> (count == $past(wdata)));
  // R9: pulse is single-cycle and seen with a zero count
  assert_pulse_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  assert_pulse_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (count == '0));
endmodule

// File: rtl/qrt_watchdog.sv
module qrt_watchdog #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rl_wr,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] wd_reload,
  output logic [CNT_W-1:0] wd_value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_reload <= '0;
      wd_value  <= '0;
    end else begin
      if (rl_wr) wd_reload <= wdata;
      if (val_wr)               wd_value <= wdata;
      else if (wd_value != '0)  wd_value <= wd_value - 1'b1;
    end
  end

  // R10: steps by one while nonzero
  assert_wd_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_wr && wd_value != '0) |=> (wd_value == $past(wd_value) - 1'b1));
  // R10: parks at zero
  assert_wd_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_wr && wd_value == '0) |=> (wd_value == '0));
endmodule

// File: rtl/qrt_top.sv
module qrt_top #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic [NUM_CH-1:0] expire
);
  import qrt_pkg::*;

  localparam logic [31:0] CTRL_MASK = ctrl_mask(NUM_CH);

  logic              ctrl_wr, wdr_wr, wdv_wr;
  logic [NUM_CH-1:0] rl_wr, val_wr;
  logic [31:0]       word_idx;
  logic [31:0]       ctrl;
  logic [DATA_W-1:0] cnt    [NUM_CH];
  logic [DATA_W-1:0] rl_val [NUM_CH];
  logic [DATA_W-1:0] wd_rl, wd_val;

  qrt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .ctrl_wr(ctrl_wr), .rl_wr(rl_wr), .val_wr(val_wr),
    .wdr_wr(wdr_wr), .wdv_wr(wdv_wr), .word_idx(word_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= 32'(bus_wdata) & CTRL_MASK;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    qrt_channel #(.CNT_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .run(ctrl[2*n]), .auto_rl(ctrl[2*n+1]), .use_ref(ctrl[SRC_BIT_BASE+n]),
      .ref_tick(ref_tick), .val_wr(val_wr[n]), .rl_wr(rl_wr[n]),
      .wdata(bus_wdata), .count(cnt[n]), .reload(rl_val[n]), .expire(expire[n])
    );
  end

  qrt_watchdog #(.CNT_W(DATA_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .rl_wr(wdr_wr), .val_wr(wdv_wr),
    .wdata(bus_wdata), .wd_reload(wd_rl), .wd_value(wd_val)
  );

  always_comb begin
    bus_rdata = '0;
    if (word_idx == WORD_CTRL)   bus_rdata = DATA_W'(ctrl);
    if (word_idx == WORD_WD_RL)  bus_rdata = wd_rl;
    if (word_idx == WORD_WD_VAL) bus_rdata = wd_val;
    for (int unsigned n = 0; n < NUM_CH; n++) begin
      if (word_idx == WORD_CH_BASE + 2*n)     bus_rdata = rl_val[n];
      if (word_idx == WORD_CH_BASE + 2*n + 1) bus_rdata = cnt[n];
    end
  end

  // R2: a write selects at most one register
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, wdr_wr, wdv_wr, rl_wr, val_wr}));
  // R11: a write outside the map selects nothing
  assert_gap_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && (word_idx inside {32'd1, 32'd2, 32'd3} || word_idx > WORD_WD_VAL))
      |-> !(ctrl_wr || wdr_wr || wdv_wr || (|rl_wr) || (|val_wr)));
endmodule

// File: tb/qrt_top_tb_top.sv
`timescale 1ns/1ps
module qrt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, ref_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  expire;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_cnt [4];
  logic [31:0] m_rl  [4];
  logic [31:0] m_ctrl, m_wdr, m_wdv;
  logic [3:0]  m_exp;

  always #4 clk = ~clk;

  qrt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .expire(expire)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w == 0) return m_ctrl;
    if (w >= 4 && w <= 11) return (w % 2 == 0) ? m_rl[(w-4)/2] : m_cnt[(w-4)/2];
    if (w == 12) return m_wdr;
    if (w == 13) return m_wdv;
    return 32'h0;
  endfunction

  task automatic cyc(input bit en, input bit we, input logic [7:0] a, input logic [31:0] d,
                     input bit rt, input string req, output logic [31:0] got);
    logic [31:0] nc [4];
    logic [31:0] nr [4];
    logic [3:0]  ne;
    logic [31:0] nctrl, nwdr, nwdv;
    bit wrt;
    int w;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; ref_tick = rt;
    #1;
    got = bus_rdata;
    if (en && !we) check(req, bus_rdata, mread(a));
    wrt = en && we;
    w = int'(a[7:2]);
    for (int n = 0; n < 4; n++) begin
      bit tk, vw, rw;
      tk = m_ctrl[2*n] && (!m_ctrl[11+n] || rt);
      vw = wrt && (w == 5 + 2*n);
      rw = wrt && (w == 4 + 2*n);
      nr[n] = rw ? d : m_rl[n];
      if (vw) nc[n] = d;
      else if (rw && m_cnt[n] == 0) nc[n] = d;
      else if (tk) nc[n] = (m_cnt[n] == 0) ? (m_ctrl[2*n+1] ? m_rl[n] : 32'h0) : m_cnt[n] - 1;
      else nc[n] = m_cnt[n];
      ne[n] = !vw && tk && (m_cnt[n] == 1);
    end
    nctrl = (wrt && w == 0) ? (d & 32'h0000_78FF) : m_ctrl;
    nwdr  = (wrt && w == 12) ? d : m_wdr;
    nwdv  = (wrt && w == 13) ? d : ((m_wdv != 0) ? m_wdv - 1 : 32'h0);
    @(posedge clk);
    #1;
    for (int n = 0; n < 4; n++) begin m_cnt[n] = nc[n]; m_rl[n] = nr[n]; end
    m_ctrl = nctrl; m_wdr = nwdr; m_wdv = nwdv; m_exp = ne;
    check("R9 expire", {28'h0, expire}, {28'h0, m_exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    logic [31:0] g;
    cyc(1, 1, a, d, 0, req, g);
  endtask
  task automatic rd(input logic [7:0] a, input string req, output logic [31:0] g);
    cyc(1, 0, a, 32'h0, 0, req, g);
  endtask
  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string req);
    logic [31:0] g;
    rd(a, req, g);
    check(req, g, e);
  endtask
  task automatic idle(input int k, input bit rt);
    logic [31:0] g;
    for (int i = 0; i < k; i++) cyc(0, 0, 8'h0, 32'h0, rt, "idle", g);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    logic [31:0] g;
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4; n++) begin m_cnt[n] = 0; m_rl[n] = 0; end
    m_ctrl = 0; m_wdr = 0; m_wdv = 0; m_exp = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 expire in reset", {28'h0, expire}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd_exp(8'(i*4), 32'h0, "R1 reset value");

    // R3: control mask
    wr(8'h00, 32'hFFFF_FFFF, "R3");
    rd_exp(8'h00, 32'h0000_78FF, "R3 control mask");
    wr(8'h00, 32'h0, "R3");
    for (int n = 0; n < 4; n++) begin wr(8'(16+8*n), 0, "R2"); wr(8'(20+8*n), 0, "R2"); end

    // R11: gaps
    wr(8'h04, 32'hDEAD_BEEF, "R11");
    wr(8'h3C, 32'hDEAD_BEEF, "R11");
    rd_exp(8'h04, 32'h0, "R11 gap read");
    rd_exp(8'h3C, 32'h0, "R11 beyond map");
    rd_exp(8'h00, 32'h0, "R11 control untouched");

    // R2: map
    wr(8'h14, 32'd10, "R2"); rd_exp(8'h14, 32'd10, "R2 ch0 count");
    wr(8'h10, 32'd77, "R2"); rd_exp(8'h10, 32'd77, "R2 ch0 reload");
    wr(8'h2C, 32'h1234, "R2"); rd_exp(8'h2C, 32'h1234, "R2 ch3 count");

    // R4: core clock stepping
    wr(8'h00, 32'h1, "R4");
    rd_exp(8'h14, 32'd10, "R4 first edge after enable");
    rd_exp(8'h14, 32'd9, "R4 step");
    idle(3, 0);
    rd_exp(8'h14, 32'd5, "R4 step count");

    // R8: write wins
    wr(8'h14, 32'd50, "R8");
    rd_exp(8'h14, 32'd50, "R8 write over step");

    // R5: hold and resume
    wr(8'h00, 32'h0, "R5");
    idle(4, 0);
    rd_exp(8'h14, 32'd48, "R5 hold");
    wr(8'h00, 32'h1, "R5");
    rd_exp(8'h14, 32'd48, "R5 resume");
    rd_exp(8'h14, 32'd47, "R5 resume step");

    // R9 / R7
    wr(8'h00, 32'h0, "R7");
    wr(8'h14, 32'd2, "R9");
    wr(8'h00, 32'h1, "R9");
    idle(1, 0);
    idle(1, 0);
    check("R9 pulse high", {31'h0, expire[0]}, 32'h1);
    idle(1, 0);
    check("R9 pulse one cycle", {31'h0, expire[0]}, 32'h0);
    idle(5, 0);
    rd_exp(8'h14, 32'd0, "R7 parked");
    wr(8'h10, 32'd7, "R7");
    rd_exp(8'h14, 32'd7, "R7 reload restarts");
    wr(8'h00, 32'h0, "R9");
    wr(8'h14, 32'd0, "R9");
    check("R9 no pulse on zero write", {31'h0, expire[0]}, 32'h0);

    // R6: wrap
    wr(8'h10, 32'hFFFF_FFFF, "R6");
    wr(8'h14, 32'd1, "R6");
    wr(8'h00, 32'h3, "R6");
    idle(1, 0);
    rd_exp(8'h14, 32'd0, "R6 at zero");
    rd_exp(8'h14, 32'hFFFF_FFFF, "R6 wrap");
    rd_exp(8'h14, 32'hFFFF_FFFE, "R6 continues");

    // R4: reference tick
    wr(8'h00, 32'h0, "R4");
    wr(8'h1C, 32'd20, "R4");
    wr(8'h00, 32'h1004, "R4");
    idle(5, 0);
    rd_exp(8'h1C, 32'd20, "R4 no strobe");
    idle(3, 1);
    rd_exp(8'h1C, 32'd17, "R4 strobe steps");

    // R10: watchdog
    wr(8'h34, 32'd3, "R10");
    rd_exp(8'h34, 32'd3, "R10 value");
    rd_exp(8'h34, 32'd2, "R10 step");
    idle(3, 0);
    rd_exp(8'h34, 32'd0, "R10 park");
    wr(8'h30, 32'hABCD, "R10");
    rd_exp(8'h30, 32'hABCD, "R10 reload");

    // random mix against model
    for (int i = 0; i < 4000; i++) begin
      int r, w;
      logic [31:0] d;
      bit rt;
      r  = int'($urandom % 10);
      rt = ($urandom % 3) == 0;
      w  = int'($urandom % 16);
      if (w == 0) d = $urandom;
      else if (w >= 4 && w <= 11 && (w % 2 == 1)) d = $urandom_range(0, 12);
      else if (w >= 4 && w <= 11) d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom_range(0, 9);
      else if (w == 13) d = $urandom_range(0, 30);
      else d = $urandom;
      if (r < 4)      cyc(0, 0, 8'h0, 32'h0, rt, "idle", g);
      else if (r < 7) cyc(1, 1, 8'(w*4 + int'($urandom % 4)), d, rt, "R2 random write", g);
      else            cyc(1, 0, 8'(w*4), 32'h0, rt, "R4 random read", g);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule